// File: doc/BRIEF.md
# Strobe-Programmed Host DMA Channel

This block moves 16-bit words between a disk controller's word FIFO and a host memory bus. A local processor drives it over an 8-bit bus with two active-low strobes. A falling edge on the select strobe latches a one-byte state code. The next falling edge on the data strobe either carries that state's operand or returns a status byte on the read bus. Any action a state triggers takes place on that falling edge of the data strobe.

The host side is a request/acknowledge word port. The channel raises `hreq` with a 23-bit word address and a direction, and holds them until `hack` is seen high at a clock edge. In one direction it writes host memory with words taken from the FIFO. In the other it reads host memory and pushes the returned words into the FIFO. The disk side pushes or pops words through its own simple strobes.

A transfer runs in one of two modes. Block mode moves `BLK_WORDS` words at consecutive word addresses. Single-word mode moves one word and then falls back to block mode. The channel also drives an active-low interrupt to the host that signals a finished command. A two-code sequence resets the transfer logic, empties the FIFO and clears its error flags.

Top module: `strobe_dma_chan`

## Requirements
- R1: After reset `irq_n` is 1 and `hreq` is 0. A status read returns 0xE0.
- R2: Code 0xFB sets the address high byte. Operand bits 6:0 drive `haddr[23:17]`. Operand bit 7 = 0 selects a write to host memory (`hwe`=1), and bit 7 = 1 selects a read from host memory (`hwe`=0). Code 0xFD drives `haddr[16:9]` from its operand. Code 0xDE drives `haddr[8:1]` from its operand and starts a transfer.
- R3: In block mode the channel moves exactly `BLK_WORDS` words. Word k uses the programmed address plus k. Each `hreq` holds steady with a stable address until `hack`. After the last word `hreq` stays low.
- R4: Code 0xDF arms single-word mode. The next transfer moves one word, leaves the address unchanged and clears the arm (status bit 1).
- R5: Host writes take FIFO words oldest first, and the request waits while the FIFO is empty. Words read from the host enter the FIFO and leave on `disk_rdata` in the same order. The FIFO holds `DEPTH` (8) words.
- R6: A disk push into a full FIFO sets the overflow flag (status bit 4) and drops the word. A disk pop from an empty FIFO sets the underflow flag (status bit 3). Both flags stay set until the reset sequence.
- R7: Code 0x7F followed directly by code 0xFF stops any transfer, drops `hreq`, empties the FIFO and clears both flags. Any other code after 0x7F cancels the pending reset.
- R8: After code 0xEF, a data strobe returns status on `cpu_rdata`: bit7 idle, bit6 FIFO empty, bit5 no host request, bit4 overflow, bit3 underflow, bit2 write-to-host direction, bit1 single armed, bit0 interrupt asserted.
- R9: Code 0xBF drives `irq_n` low. It stays low until an `irq_ack` pulse.
- R10: An unknown code and its data strobe change nothing. Codes 0xFB, 0xFD, 0xDE and 0xDF have no effect while a transfer is active.
- R11: An action happens once per falling edge of the data strobe. Holding the strobe low does not repeat it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Select strobe; falling edge latches a state code |
| data_n | input | 1 | Data strobe; falling edge triggers the state's action |
| cpu_wdata | input | 8 | Code or operand from the local processor |
| cpu_rdata | output | 8 | Status byte while the data strobe is low after 0xEF, else 0 |
| hreq | output | 1 | Host word request |
| hwe | output | 1 | 1 = write to host memory, 0 = read from host memory |
| haddr | output | 23 | Host word address (byte address bits 23:1) |
| hwdata | output | 16 | Word written to the host |
| hrdata | input | 16 | Word returned by the host |
| hack | input | 1 | Host acknowledge; completes the current word |
| disk_push | input | 1 | Disk side writes `disk_wdata` into the FIFO |
| disk_wdata | input | 16 | Disk word to the FIFO |
| disk_pop | input | 1 | Disk side consumes the FIFO head |
| disk_rdata | output | 16 | FIFO head word |
| irq_n | output | 1 | Active-low command-complete interrupt |
| irq_ack | input | 1 | Host interrupt acknowledge pulse |

## Verification
A bad mode or counter state shows up at the host port within one word cycle. A stuck single-word arm makes a block stop after one request. A miscounted block raises a request beyond the last word, and a wrong address step shows on `haddr` at the second request. A wrong FIFO pointer or flag appears at the next `disk_rdata` pop or the next status read, because every flag and the idle, empty and request-free bits are mirrored in the status byte. A missed strobe edge or a repeated one shows as a missing or extra `hreq` a cycle after the strobe.

// File: rtl/strobe_dma_chan.sv
module strobe_dma_chan #(
  parameter int DEPTH     = 8,
  parameter int BLK_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        data_n,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        hreq,
  output logic        hwe,
  output logic [23:1] haddr,
  output logic [15:0] hwdata,
  input  logic [15:0] hrdata,
  input  logic        hack,
  input  logic        disk_push,
  input  logic [15:0] disk_wdata,
  input  logic        disk_pop,
  output logic [15:0] disk_rdata,
  output logic        irq_n,
  input  logic        irq_ack
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int BCW = $clog2(BLK_WORDS + 1);
  localparam logic [BCW-1:0] LAST = BCW'(BLK_WORDS - 1);
  localparam logic [CW-1:0]  FULL = CW'(DEPTH);

  localparam logic [7:0] C_IRQ  = 8'hBF;
  localparam logic [7:0] C_ONE  = 8'hDF;
  localparam logic [7:0] C_CLR1 = 8'h7F;
  localparam logic [7:0] C_CLR2 = 8'hFF;
  localparam logic [7:0] C_HI   = 8'hFB;
  localparam logic [7:0] C_MID  = 8'hFD;
  localparam logic [7:0] C_GO   = 8'hDE;
  localparam logic [7:0] C_STAT = 8'hEF;

  logic           sel_q, data_q;
  logic [7:0]     code, rd_q;
  logic           armed, active, single, dir_wr, ovf, udf;
  logic [22:0]    waddr;
  logic [BCW-1:0] blk_cnt;
  logic [15:0]    mem [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;

  wire sel_fall  = sel_q & ~sel_n;
  wire data_fall = data_q & ~data_n;
  wire clr       = sel_fall && cpu_wdata == C_CLR2 && armed;
  wire cmd_ok    = data_fall && !active;
  wire empty     = cnt == '0;
  wire full      = cnt == FULL;
  wire issue     = active && !hreq && (dir_wr ? !empty : !full);
  wire done      = hreq && hack;

  wire dma_pop   = issue && dir_wr;
  wire dma_push  = done && !dir_wr;
  wire dsk_push  = disk_push && !dma_push && !full;
  wire dsk_pop   = disk_pop && !dma_pop && !empty;
  wire do_push   = (dma_push && !full) || dsk_push;
  wire do_pop    = dma_pop || dsk_pop;
  wire ovf_set   = (disk_push && (full || dma_push)) || (dma_push && full);
  wire udf_set   = disk_pop && (empty || dma_pop);
  wire [15:0] push_data = dma_push ? hrdata : disk_wdata;

  wire [7:0] stat = {!active, empty, !hreq, ovf, udf, dir_wr, single, !irq_n};

  assign haddr      = waddr;
  assign hwe        = dir_wr;
  assign disk_rdata = mem[rp];
  assign cpu_rdata  = (!data_n && code == C_STAT) ? rd_q : 8'h00;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b1; data_q <= 1'b1; code <= 8'h00; rd_q <= 8'h00;
      armed <= 1'b0; irq_n <= 1'b1; active <= 1'b0; hreq <= 1'b0;
      single <= 1'b0; dir_wr <= 1'b0; waddr <= '0; blk_cnt <= '0;
      hwdata <= '0;
    end else begin
      sel_q  <= sel_n;
      data_q <= data_n;
      if (sel_fall) begin
        code  <= cpu_wdata;
        armed <= cpu_wdata == C_CLR1;
      end
      if (data_fall && code == C_STAT) rd_q <= stat;
      if (irq_ack) irq_n <= 1'b1;
      if (data_fall && code == C_IRQ) irq_n <= 1'b0;
      if (clr) begin
        active <= 1'b0; hreq <= 1'b0; single <= 1'b0; blk_cnt <= '0;
      end else begin
        if (cmd_ok) begin
          case (code)
            C_HI:  {dir_wr, waddr[22:16]} <= {~cpu_wdata[7], cpu_wdata[6:0]};
            C_MID: waddr[15:8] <= cpu_wdata;
            C_ONE: single <= 1'b1;
            C_GO: begin
              waddr[7:0] <= cpu_wdata;
              active     <= 1'b1;
              blk_cnt    <= '0;
            end
            default: ;
          endcase
        end
        if (issue) begin
          hreq <= 1'b1;
          if (dir_wr) hwdata <= mem[rp];
        end
        if (done) begin
          hreq <= 1'b0;
          if (single) begin
            single <= 1'b0;
            active <= 1'b0;
          end else begin
            waddr   <= waddr + 23'd1;
            blk_cnt <= blk_cnt + BCW'(1);
            if (blk_cnt == LAST) active <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0; udf <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (ovf_set) ovf <= 1'b1;
      if (udf_set) udf <= 1'b1;
    end
  end

  // R3
  hreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq && !hack && !clr) |=> (hreq && $stable(haddr) && $stable(hwe)));
  // R3
  req_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq |-> active);
  // R4
  single_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && single && !clr) |=> (!active && !single));
  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  // R6
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (udf && !clr) |=> udf);
  // R7
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !ovf && !udf && !hreq && !active));
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !irq_ack) |=> !irq_n);
endmodule

// File: tb/tb_strobe_dma_chan.sv
module tb_strobe_dma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, data_n = 1'b1;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic hreq, hwe, hack = 1'b0;
  logic [23:1] haddr;
  logic [15:0] hwdata, disk_rdata;
  logic [15:0] hrdata = '0, disk_wdata = '0;
  logic disk_push = 1'b0, disk_pop = 1'b0, irq_n, irq_ack = 1'b0;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  strobe_dma_chan #(.DEPTH(8), .BLK_WORDS(4)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .data_n(data_n),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .hreq(hreq), .hwe(hwe),
    .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata), .hack(hack),
    .disk_push(disk_push), .disk_wdata(disk_wdata), .disk_pop(disk_pop),
    .disk_rdata(disk_rdata), .irq_n(irq_n), .irq_ack(irq_ack));

  typedef struct packed { logic [7:0] hi, mid, lo; logic [15:0] d; } vec_t;
  localparam vec_t VEC [4] = '{
    '{8'h80, 8'h12, 8'h06, 16'hBEEF},
    '{8'h7F, 8'hA5, 8'hFF, 16'h1234},
    '{8'hC3, 8'h00, 8'h00, 16'h0F0F},
    '{8'h01, 8'hFF, 8'h80, 16'hCAFE}};

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic sel(input logic [7:0] c);
    @(negedge clk) cpu_wdata = c; sel_n = 1'b0;
    @(negedge clk) sel_n = 1'b1;
  endtask

  task automatic dat(input logic [7:0] v);
    @(negedge clk) cpu_wdata = v; data_n = 1'b0;
    @(negedge clk) data_n = 1'b1;
  endtask

  task automatic cmd(input logic [7:0] c, input logic [7:0] v);
    sel(c); dat(v);
  endtask

  task automatic rd_stat(output logic [7:0] s);
    sel(8'hEF);
    @(negedge clk) data_n = 1'b0;
    @(negedge clk) s = cpu_rdata; data_n = 1'b1;
  endtask

  task automatic wait_req(input string r);
    int n = 0;
    @(negedge clk);
    while (!hreq && n < 20) begin @(negedge clk); n++; end
    chk(hreq === 1'b1, r, hreq, 1);
  endtask

  task automatic ack(input logic [15:0] d);
    hrdata = d; hack = 1'b1;
    @(negedge clk) hack = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk) disk_wdata = d; disk_push = 1'b1;
    @(negedge clk) disk_push = 1'b0;
  endtask

  task automatic pop(input bit check, input logic [15:0] e, input string r);
    @(negedge clk);
    if (check) chk(disk_rdata === e, r, disk_rdata, e);
    disk_pop = 1'b1;
    @(negedge clk) disk_pop = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [22:0] ea;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(irq_n === 1'b1, "R1 irq_n", irq_n, 1);
    chk(hreq === 1'b0, "R1 hreq", hreq, 0);
    rd_stat(s);
    chk(s === 8'hE0, "R1 status", s, 8'hE0);

    // table of single-word transfers in both directions (R2, R4, R5)
    for (int i = 0; i < 4; i++) begin
      ea = {VEC[i].hi[6:0], VEC[i].mid, VEC[i].lo};
      if (!VEC[i].hi[7]) push(VEC[i].d);
      cmd(8'hFB, VEC[i].hi);
      cmd(8'hFD, VEC[i].mid);
      cmd(8'hDF, 8'h00);
      cmd(8'hDE, VEC[i].lo);
      wait_req("R2 request");
      chk(haddr === ea, "R2 haddr", haddr, ea);
      chk(hwe === ~VEC[i].hi[7], "R2 hwe", hwe, ~VEC[i].hi[7]);
      if (!VEC[i].hi[7]) chk(hwdata === VEC[i].d, "R5 hwdata", hwdata, VEC[i].d);
      ack(VEC[i].d);
      repeat (3) @(negedge clk);
      chk(hreq === 1'b0, "R4 single stops", hreq, 0);
      chk(haddr === ea, "R4 address kept", haddr, ea);
      if (VEC[i].hi[7]) pop(1'b1, VEC[i].d, "R5 read word");
    end
    rd_stat(s);
    chk(s === 8'hE4, "R4 R8 arm cleared, write dir", s, 8'hE4);

    // R3 block read of 4 words, R10 config ignored while active
    cmd(8'hFB, 8'h80); cmd(8'hFD, 8'h10); cmd(8'hDE, 8'h20);
    for (int i = 0; i < 4; i++) begin
      wait_req("R3 block request");
      ea = {7'h00, 8'h10, 8'h20} + 23'(i);
      chk(haddr === ea, "R3 block address", haddr, ea);
      if (i == 1) begin
        cmd(8'hFB, 8'h05);
        @(negedge clk);
        chk(haddr === ea && hwe === 1'b0, "R10 config while active", haddr, ea);
      end
      ack(16'h0100 + 16'(i));
    end
    repeat (4) @(negedge clk);
    chk(hreq === 1'b0, "R3 block ends", hreq, 0);
    rd_stat(s);
    chk(s === 8'hA0, "R8 status with data", s, 8'hA0);
    for (int i = 0; i < 4; i++) pop(1'b1, 16'h0100 + 16'(i), "R5 block order");

    // R5 block write to host, oldest first
    for (int i = 0; i < 4; i++) push(16'hA000 + 16'(i));
    cmd(8'hFB, 8'h00); cmd(8'hFD, 8'h00); cmd(8'hDE, 8'h00);
    for (int i = 0; i < 4; i++) begin
      wait_req("R5 write request");
      chk(hwdata === 16'hA000 + 16'(i), "R5 write order", hwdata, 16'hA000 + 16'(i));
      ack(16'h0000);
    end
    repeat (3) @(negedge clk);
    chk(hreq === 1'b0, "R5 write stalls on empty", hreq, 0);

    // R11 held data strobe acts once
    cmd(8'hFB, 8'h80);
    cmd(8'hDF, 8'h00);
    sel(8'hDE);
    @(negedge clk) cpu_wdata = 8'h40; data_n = 1'b0;
    wait_req("R11 request");
    ack(16'h5555);
    repeat (6) @(negedge clk);
    chk(hreq === 1'b0, "R11 no repeat", hreq, 0);
    data_n = 1'b1;
    pop(1'b1, 16'h5555, "R11 word");

    // R6 overflow, R7 cancelled reset, underflow, stickiness
    for (int i = 0; i < 9; i++) push(16'h0200 + 16'(i));
    rd_stat(s);
    chk(s === 8'hB0, "R6 overflow", s, 8'hB0);
    sel(8'h7F);
    rd_stat(s);
    chk(s === 8'hB0, "R7 cancelled reset", s, 8'hB0);
    pop(1'b1, 16'h0200, "R6 oldest kept");
    for (int i = 1; i < 8; i++) pop(1'b0, 16'h0, "R6");
    pop(1'b0, 16'h0, "R6");
    rd_stat(s);
    chk(s === 8'hF8, "R6 underflow", s, 8'hF8);
    push(16'h7777); pop(1'b0, 16'h0, "R6");
    rd_stat(s);
    chk(s === 8'hF8, "R6 sticky", s, 8'hF8);
    push(16'h8888);
    sel(8'h7F); sel(8'hFF);
    rd_stat(s);
    chk(s === 8'hE0, "R7 reset sequence", s, 8'hE0);

    // R7 reset during an active transfer
    cmd(8'hDE, 8'h00);
    wait_req("R7 request");
    sel(8'h7F); sel(8'hFF);
    @(negedge clk);
    chk(hreq === 1'b0, "R7 hreq dropped", hreq, 0);
    rd_stat(s);
    chk(s === 8'hE0, "R7 idle after reset", s, 8'hE0);

    // R10 unknown code
    cmd(8'hFD, 8'h33);
    ea = haddr;
    cmd(8'h12, 8'h99);
    chk(haddr === ea, "R10 unknown code haddr", haddr, ea);
    rd_stat(s);
    chk(s === 8'hE0, "R10 unknown code status", s, 8'hE0);

    // R9 interrupt
    cmd(8'hBF, 8'h00);
    chk(irq_n === 1'b0, "R9 irq asserted", irq_n, 0);
    repeat (5) @(negedge clk);
    chk(irq_n === 1'b0, "R9 irq held", irq_n, 0);
    irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    chk(irq_n === 1'b1, "R9 irq released", irq_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule